// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block is a serial bus master that exchanges one 8-bit word with a peripheral per transfer. The word goes out on the data output while the word coming in on the data input is gathered at the same time, most significant bit first. A small register-style write port holds the configuration. That configuration covers the frame type, the idle level of the serial clock, which clock edge samples data, a loopback switch, a master enable, and a two-stage bit-rate divider. The two divider stages are an even prescale divisor and a per-bit tick count.

To start a transfer, the user presents a word on `tx_word` and pulses `start` for one cycle. The block lowers the active-low select and drives sixteen serial clock edges. It then raises the select and presents the received word with a one-cycle `done` pulse. Only the plain four-mode SPI framing is carried out. The other frame codes can be written, but with any of them every start request is refused. With loopback set, the block feeds its own output into its input, so it can test itself without a peripheral.

Top module: `ssm_top`

## Requirements
- R1: After reset, every configuration field is 0. The block is then disabled, with `sclk` low, `cs_n` high, `busy` and `done` low, and a `start` pulse has no effect.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_addr`. Address 0 is the mode register: bits [1:0] frame code, bit 2 clock polarity, bit 3 clock phase, bit 4 loopback, bit 5 enable. Address 1 holds the rate count (8 bits). Address 2 holds the prescale divisor (8 bits). Address 3 is ignored.
- R3: A `start` pulse is accepted only when the enable bit is 1, the frame code is 00 (SPI) and `busy` is low. A pulse under frame codes 01, 10 or 11, while disabled, or during a transfer is ignored and leaves the transfer in progress unchanged.
- R4: A transfer exchanges 8 bits, most significant bit first. `busy` and a low `cs_n` are asserted from the clock edge that accepts `start` until the edge that raises `done`. `done` is high for one cycle, and `rx_word` then holds the received word.
- R5: Between transfers, `sclk` rests at the polarity bit: low for 0 and high for 1. Each transfer makes exactly 16 `sclk` transitions and ends at the rest level.
- R6: With phase 0, the first data bit is on `mosi` before the first `sclk` edge. Input is sampled on each edge that leaves the rest level, and the next output bit is driven on each edge that returns to it.
- R7: With phase 1, each output bit is driven on the edge that leaves the rest level, and input is sampled on the edge that returns to it.
- R8: With P = prescale/2 and H = P × (rate + 1) system clocks, `cs_n` falls H cycles before the first `sclk` edge. Edges are spaced H cycles apart, and `cs_n` rises H cycles after the last edge, so `cs_n` stays low for exactly 17·H cycles.
- R9: Bit 0 of the prescale divisor is ignored, and divisor values 0 and 1 act as 2.
- R10: With loopback set, input is taken from the block's own `mosi`, so `rx_word` equals the transmitted word whatever `miso` carries.
- R11: Clearing the enable bit during a transfer stops it. `cs_n` goes high, `sclk` returns to rest, `busy` drops, and no `done` pulse is given for that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| tx_word | input | 8 | Word to transmit, taken when start is accepted |
| start | input | 1 | One-cycle transfer request |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial bus clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low peripheral select |
| rx_word | output | 8 | Last received word |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest situation to reach from the ports is a transfer that is stopped partway, because the enable bit has to be cleared through the configuration port while the serial clock is in the middle of a word. The bench selects a long half-bit period so that the write lands partway through the word, and then watches the ports to confirm that no completion pulse follows. A second hard case is a start request that arrives during a transfer. It is issued a few cycles after an accepted start, and the bench confirms that both the word sent and the word received belong to the first request.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    FMT_SPI  = 2'b00,
    FMT_TI   = 2'b01,
    FMT_MW   = 2'b10,
    FMT_RSVD = 2'b11
  } frame_fmt_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_RATE  = 2'd1;
  localparam logic [1:0] ADDR_PSCAL = 2'd2;
endpackage

// File: rtl/ssm_cfg_regs.sv
module ssm_cfg_regs
  import ssm_pkg::*;
#(
  parameter int RATE_W = 8,
  localparam int PRE_W = RATE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [RATE_W-1:0] wdata,
  output frame_fmt_e        fmt,
  output logic              cpol,
  output logic              cpha,
  output logic              loop_en,
  output logic              enable,
  output logic [RATE_W-1:0] rate,
  output logic [PRE_W-1:0]  pre_half
);
  // prescale is held as divisor/2: bit 0 of the written value is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt      <= FMT_SPI;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      loop_en  <= 1'b0;
      enable   <= 1'b0;
      rate     <= '0;
      pre_half <= '0;
    end else if (we) begin
      case (addr)
        ADDR_MODE: begin
          fmt     <= frame_fmt_e'(wdata[1:0]);
          cpol    <= wdata[2];
          cpha    <= wdata[3];
          loop_en <= wdata[4];
          enable  <= wdata[5];
        end
        ADDR_RATE:  rate     <= wdata;
        ADDR_PSCAL: pre_half <= wdata[RATE_W-1:1];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ssm_clkdiv.sv
module ssm_clkdiv #(
  parameter int RATE_W = 8,
  localparam int PRE_W = RATE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre_half,
  input  logic [RATE_W-1:0] rate,
  output logic              half_tick
);
  logic [PRE_W-1:0]  pre_cnt;
  logic [RATE_W-1:0] rate_cnt;
  logic [PRE_W-1:0]  pre_lim;
  logic              pre_wrap;

  // a divisor below 2 behaves as 2, i.e. one system clock per prescaler tick
  always_comb begin
    pre_lim  = (pre_half == '0) ? '0 : pre_half - 1'b1;
    pre_wrap = (pre_cnt == pre_lim);
  end

  assign half_tick = run && pre_wrap && (rate_cnt == rate);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  a_r8_prescale_in_range: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) |-> pre_cnt <= pre_lim);
endmodule

// File: rtl/ssm_engine.sv
module ssm_engine
  import ssm_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int EDGES = 2 * WORD_W,
  localparam int ECW   = $clog2(EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_fmt_e        fmt,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              loop_en,
  input  logic              enable,
  input  logic              half_tick,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              start,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              busy
);
  localparam logic [ECW-1:0] EDGE_END = ECW'(EDGES);

  logic [WORD_W-1:0] sh_tx;
  logic [WORD_W-1:0] sh_rx;
  logic [ECW-1:0]    edge_cnt;
  logic              go;
  logic              ser_in;
  logic              sample_edge;

  assign go          = start && enable && (fmt == FMT_SPI) && !busy;
  assign ser_in      = loop_en ? mosi : miso;
  // even edge index = leaving rest level; phase picks which one samples
  assign sample_edge = (edge_cnt[0] == cpha);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_word  <= '0;
      done     <= 1'b0;
      edge_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        cs_n <= 1'b1;
        if (go) begin
          busy     <= 1'b1;
          cs_n     <= 1'b0;
          edge_cnt <= '0;
          sh_rx    <= '0;
          if (!cpha) begin
            mosi  <= tx_word[WORD_W-1];
            sh_tx <= {tx_word[WORD_W-2:0], 1'b0};
          end else begin
            sh_tx <= tx_word;
          end
        end
      end else if (!enable) begin
        busy <= 1'b0;
        cs_n <= 1'b1;
        sclk <= cpol;
        mosi <= 1'b0;
      end else if (half_tick) begin
        if (edge_cnt == EDGE_END) begin
          busy    <= 1'b0;
          cs_n    <= 1'b1;
          done    <= 1'b1;
          rx_word <= sh_rx;
          mosi    <= 1'b0;
        end else begin
          sclk     <= ~sclk;
          edge_cnt <= edge_cnt + 1'b1;
          if (sample_edge) begin
            sh_rx <= {sh_rx[WORD_W-2:0], ser_in};
          end else begin
            mosi  <= sh_tx[WORD_W-1];
            sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  a_r5_sclk_rests: assert property (@(posedge clk) disable iff (rst)
    cs_n && $past(cs_n) && $stable(cpol) |-> sclk == cpol);

  a_r3_accept_only_allowed: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start && enable && fmt == FMT_SPI));

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_done_closes_frame: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && cs_n);

  a_r4_select_tracks_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  a_r11_abort_no_done: assert property (@(posedge clk) disable iff (rst)
    $past(busy && !enable) |-> !done && !busy);
endmodule

// File: rtl/ssm_top.sv
module ssm_top
  import ssm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int RATE_W = 8,
  localparam int PRE_W = RATE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [RATE_W-1:0] cfg_wdata,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              start,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              busy
);
  frame_fmt_e        fmt;
  logic              cpol, cpha, loop_en, enable, half_tick;
  logic [RATE_W-1:0] rate;
  logic [PRE_W-1:0]  pre_half;

  ssm_cfg_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .fmt(fmt), .cpol(cpol), .cpha(cpha), .loop_en(loop_en), .enable(enable),
    .rate(rate), .pre_half(pre_half)
  );

  ssm_clkdiv #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .pre_half(pre_half), .rate(rate),
    .half_tick(half_tick)
  );

  ssm_engine #(.WORD_W(WORD_W)) u_eng (
    .clk(clk), .rst(rst), .fmt(fmt), .cpol(cpol), .cpha(cpha),
    .loop_en(loop_en), .enable(enable), .half_tick(half_tick),
    .tx_word(tx_word), .start(start), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .rx_word(rx_word), .done(done), .busy(busy)
  );
endmodule

// File: tb/ssm_top_bench.sv
module ssm_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] tx_word = '0;
  logic       start = 1'b0;
  logic       miso = 1'b0;
  logic       sclk, mosi, cs_n, done, busy;
  logic [7:0] rx_word;

  int tests = 0;
  int fails = 0;

  // peripheral model state
  logic       b_cpol = 1'b0, b_cpha = 1'b0;
  logic [7:0] slv_word = '0, slv_sh = '0, slv_rx = '0;
  int         slv_edges = 0;

  always #2 clk = ~clk;

  ssm_top u_ssm_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_word(tx_word), .start(start), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rx_word(rx_word), .done(done),
    .busy(busy)
  );

  always @(negedge cs_n) begin
    slv_sh = slv_word;
    slv_rx = '0;
    slv_edges = 0;
    if (!b_cpha) begin
      miso = slv_sh[7];
      slv_sh = {slv_sh[6:0], 1'b0};
    end
  end

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      slv_edges++;
      if ((sclk != b_cpol) ^ b_cpha) begin
        slv_rx = {slv_rx[6:0], mosi};
      end else begin
        miso = slv_sh[7];
        slv_sh = {slv_sh[6:0], 1'b0};
      end
    end
  end

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] fmt, input logic pol,
                          input logic pha, input logic lp, input logic en);
    b_cpol = pol; b_cpha = pha;
    cfg_write(2'd0, {2'b00, en, lp, pha, pol, fmt});
    repeat (2) @(negedge clk);
  endtask

  function automatic int half_period(input int psc, input int rate);
    int p;
    p = psc / 2;
    if (p < 1) p = 1;
    return p * (rate + 1);
  endfunction

  task automatic pulse_start(input logic [7:0] w);
    @(negedge clk);
    tx_word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // full transfer, checking data, timing and rest level
  task automatic xfer(input string req, input logic [7:0] w,
                      input logic [7:0] sw, input logic [7:0] exp_rx,
                      input int h);
    int low_cycles;
    int guard;
    slv_word = sw;
    pulse_start(w);
    check(req, "busy after accept", int'(busy), 1);
    low_cycles = 0;
    guard = 0;
    while (!done && guard < 20000) begin
      if (!cs_n) low_cycles++;
      guard++;
      @(negedge clk);
    end
    check(req, "rx_word", int'(rx_word), int'(exp_rx));
    check(req, "word seen by peripheral", int'(slv_rx), int'(w));
    check("R8", "select low cycles", low_cycles, 17 * h);
    check("R5", "sclk transitions", slv_edges, 16);
    check("R5", "sclk rest level", int'(sclk), int'(b_cpol));
    @(negedge clk);
    check("R4", "done single cycle", int'(done), 0);
    check("R4", "busy cleared", int'(busy), 0);
  endtask

  task automatic t_reset;
    check("R1", "sclk low", int'(sclk), 0);
    check("R1", "cs_n high", int'(cs_n), 1);
    check("R1", "busy low", int'(busy), 0);
    check("R1", "done low", int'(done), 0);
    pulse_start(8'hFF);
    repeat (3) @(negedge clk);
    check("R1", "start ignored while disabled", int'(busy), 0);
    check("R1", "select stays high", int'(cs_n), 1);
  endtask

  task automatic t_ignored_format(input logic [1:0] f);
    set_mode(f, 1'b0, 1'b0, 1'b0, 1'b1);
    pulse_start(8'h33);
    repeat (4) @(negedge clk);
    check("R3", "non-SPI start ignored busy", int'(busy), 0);
    check("R3", "non-SPI start ignored cs_n", int'(cs_n), 1);
  endtask

  task automatic t_mode(input string req, input logic pol, input logic pha,
                        input int psc, input int rate,
                        input logic [7:0] w, input logic [7:0] sw);
    cfg_write(2'd2, 8'(psc));
    cfg_write(2'd1, 8'(rate));
    set_mode(2'b00, pol, pha, 1'b0, 1'b1);
    check("R5", "rest level before transfer", int'(sclk), int'(pol));
    xfer(req, w, sw, sw, half_period(psc, rate));
  endtask

  task automatic t_loopback;
    cfg_write(2'd2, 8'd2);
    cfg_write(2'd1, 8'd0);
    set_mode(2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    xfer("R10", 8'h96, 8'h00, 8'h96, 1);
    set_mode(2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
    xfer("R10", 8'h3B, 8'hFF, 8'h3B, 1);
  endtask

  task automatic t_start_while_busy;
    int h;
    cfg_write(2'd2, 8'd4);
    cfg_write(2'd1, 8'd1);
    set_mode(2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    h = half_period(4, 1);
    slv_word = 8'h5C;
    pulse_start(8'hA3);
    repeat (3) @(negedge clk);
    pulse_start(8'h11);
    while (!done) @(negedge clk);
    check("R3", "busy start: rx of first", int'(rx_word), 8'h5C);
    check("R3", "busy start: tx of first", int'(slv_rx), 8'hA3);
    repeat (2 * h) begin
      @(negedge clk);
      check("R3", "no second transfer", int'(busy), 0);
    end
  endtask

  task automatic t_abort;
    int seen;
    cfg_write(2'd2, 8'd20);
    cfg_write(2'd1, 8'd3);
    set_mode(2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
    pulse_start(8'h77);
    repeat (60) @(negedge clk);
    check("R11", "mid transfer select low", int'(cs_n), 0);
    cfg_write(2'd0, {2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00});
    @(negedge clk);
    check("R11", "select high after abort", int'(cs_n), 1);
    check("R11", "busy low after abort", int'(busy), 0);
    check("R11", "sclk at rest after abort", int'(sclk), 1);
    seen = 0;
    repeat (800) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R11", "no done after abort", seen, 0);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ignored_format(2'b01);
    t_ignored_format(2'b10);
    t_ignored_format(2'b11);
    // R2 R6: phase 0, polarity 0, divisor 2 rate 0
    t_mode("R6", 1'b0, 1'b0, 2, 0, 8'hA5, 8'h3C);
    // R7: phase 1, polarity 0
    t_mode("R7", 1'b0, 1'b1, 4, 1, 8'h81, 8'h7E);
    // R6 R8: polarity 1, phase 0, divisor 6 rate 2
    t_mode("R6", 1'b1, 1'b0, 6, 2, 8'h5A, 8'hC3);
    // R9: odd divisor 5 acts as 4
    t_mode("R9", 1'b1, 1'b1, 5, 3, 8'h0F, 8'hF0);
    // R9: divisor 0 acts as 2
    t_mode("R9", 1'b0, 1'b1, 0, 0, 8'hC9, 8'h26);
    t_loopback();
    t_start_while_busy();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule